// File: doc/BRIEF.md
# Symmetric Half-Rate FIR Decimator

This block is a four-tap, linear-phase FIR filter that also halves the sample rate. Samples arrive as 18-bit signed words, qualified by an enable strobe. Every second accepted sample starts one output computation. Because the taps are symmetric, only two coefficients exist. The matching sample pairs are added before multiplication, so a single multiplier handles both pairs on consecutive clocks. An accumulator sums the two products, clearing at the start of each round and adding on the next clock.

The output is the low 18 bits of the 36-bit sum. It is presented with a valid flag that is high for one clock. Each result appears a fixed eight clocks after the sample that completed it. Under an unbroken input stream the block produces one result every two clocks. Its output strobe has the same form as its input strobe, so one instance can feed another directly. The two coefficients are fixed by parameters.

Top module: `sym_fir_dec2`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `vld` low and `dout` zero. Reset also empties the delay line, so the taps that follow reset start from zero. Any computation in flight at reset never produces a valid output.
- R2: A sample on `din` is taken only at a rising edge where `en` is high. Clocks with `en` low neither shift the delay line nor advance the pairing of samples, whatever `din` holds.
- R3: Counting accepted samples from 1 after reset, each even-numbered sample x(n) yields y = H0·(x(n)+x(n-3)) + H1·(x(n-1)+x(n-2)). Only the low 18 bits are kept, as a two's-complement value on `dout`.
- R4: `vld` goes high in the cycle that follows the eighth rising edge after the edge that accepted x(n).
- R5: `vld` is never high on two consecutive cycles. If `en` is held high, results come out on every second cycle.
- R6: Each sample must have its top two bits equal. This gives the 18-bit pair sum one bit of headroom so that it cannot overflow.
- R7: `dout` changes only in a cycle where `vld` is high, and holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Input sample qualifier |
| din | input | 18 | Signed input sample |
| dout | output | 18 | Filtered, decimated sample (low 18 bits of sum) |
| vld | output | 1 | One-cycle strobe marking a new `dout` |

## Verification
Some properties are checked on every cycle. These are the input headroom rule, the one-cycle width of `vld`, `dout` holding still between pulses, the quiet state after reset, and the rule that every pulse traces back to an enabled edge nine samples of the clock earlier. Other behaviour can only be shown by the bench's scenarios. That covers the filter arithmetic and the wrap to 18 bits, the choice of which accepted samples complete a result, the exact eight-clock latency, and the rule that idle clocks with changing `din` leave the pairing untouched. The same holds for flushing the delay line on a mid-stream reset. For these, the bench compares each result against a model of the taps and its predicted cycle.

// File: rtl/sym_fir_dec2.sv
module sym_fir_dec2 #(
  parameter int W  = 18,
  parameter int H0 = 1500,
  parameter int H1 = -3000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout,
  output logic                vld
);
  localparam int PW  = 2 * W;
  localparam int LAT = 8;
  localparam logic signed [W-1:0] C0 = W'(H0);
  localparam logic signed [W-1:0] C1 = W'(H1);

  logic signed [W-1:0]  t0, t1, t2;
  logic signed [W-1:0]  oa, ob, ia, ib;
  logic                 ph;
  logic [LAT-1:0]       go;
  logic signed [W-1:0]  add_r, add_q;
  logic signed [PW-1:0] mul_r, mul_q, acc, acc_o;

  wire launch = en & ph;
  wire signed [W-1:0] coef = go[2] ? C0 : C1;

  always_ff @(posedge clk) begin
    if (rst) begin
      t0 <= '0; t1 <= '0; t2 <= '0; ph <= 1'b0;
      oa <= '0; ob <= '0; ia <= '0; ib <= '0;
      go <= '0;
      add_r <= '0; add_q <= '0;
      mul_r <= '0; mul_q <= '0;
      acc <= '0; acc_o <= '0;
      dout <= '0; vld <= 1'b0;
    end else begin
      if (en) begin
        t0 <= din; t1 <= t0; t2 <= t1;
        ph <= ~ph;
      end
      if (launch) begin
        oa <= din; ob <= t2;
        ia <= t0;  ib <= t1;
      end
      go    <= {go[LAT-2:0], launch};
      add_r <= go[0] ? oa + ob : ia + ib;
      add_q <= add_r;
      mul_r <= add_q * coef;
      mul_q <= mul_r;
      if (go[4])      acc <= mul_q;
      else if (go[5]) acc <= acc + mul_q;
      if (go[6]) acc_o <= acc;
      if (go[7]) dout  <= acc_o[W-1:0];
      vld <= go[7];
    end
  end
endmodule

// File: rtl/sym_fir_dec2_chk.sv
module sym_fir_dec2_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         vld
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!vld && dout == '0));

  a_r4_launch_origin: assert property (@(posedge clk) disable iff (rst)
    vld |-> $past(en, 9));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    vld |=> !vld);

  a_r6_headroom: assert property (@(posedge clk) disable iff (rst)
    en |-> (din[W-1] == din[W-2]));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !vld |-> $stable(dout));
endmodule

bind sym_fir_dec2 sym_fir_dec2_chk #(.W(W)) chk (
  .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout), .vld(vld)
);

// File: tb/sym_fir_dec2_test.sv
module sym_fir_dec2_test;
  localparam int W  = 18;
  localparam int H0 = 1500;
  localparam int H1 = -3000;
  localparam int NV = 16;
  localparam logic signed [W-1:0] VEC [0:NV-1] = '{
    18'sd100, 18'sd200, -18'sd50, 18'sd7, 18'sd65535, -18'sd65536, 18'sd1, 18'sd0,
    -18'sd1234, 18'sd4321, 18'sd999, -18'sd3, 18'sd32000, -18'sd32000, 18'sd12, 18'sd77
  };

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic signed [W-1:0] din = '0;
  logic signed [W-1:0] dout;
  logic vld;

  sym_fir_dec2 #(.W(W), .H0(H0), .H1(H1)) uut (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout), .vld(vld)
  );

  always #2.5 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, nacc = 0, wp = 0, rp = 0;
  bit done = 0;
  longint hx [0:3];
  int exp_cyc [0:255];
  logic [W-1:0] exp_val [0:255];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) hx[i] = 0;
    nacc = 0;
    rp = wp;
  endtask

  task automatic put(input logic signed [W-1:0] x);
    longint y;
    @(negedge clk);
    en = 1'b1; din = x;
    for (int i = 3; i > 0; i--) hx[i] = hx[i-1];
    hx[0] = longint'(x);
    nacc++;
    if (nacc % 2 == 0) begin
      y = longint'(H0) * (hx[0] + hx[3]) + longint'(H1) * (hx[1] + hx[2]);
      exp_cyc[wp % 256] = cyc + 1 + 8;
      exp_val[wp % 256] = y[W-1:0];
      wp++;
    end
  endtask

  task automatic idle(input int n, input logic signed [W-1:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b0; din = junk + W'(i);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (vld) begin
        if (rp < wp) begin
          chk(exp_cyc[rp % 256] == cyc, "R4 latency", cyc, exp_cyc[rp % 256]);
          chk(dout == exp_val[rp % 256], "R3 value", dout, exp_val[rp % 256]);
          rp++;
        end else chk(0, "R2/R5 unexpected vld", 1, 0);
      end else if (rp < wp && exp_cyc[rp % 256] <= cyc) begin
        chk(0, "R4 missing vld", 0, 1);
        rp++;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R1 vld in reset", vld, 0);
    chk(dout == '0, "R1 dout in reset", dout, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) put(VEC[i]);
    idle(12, 18'sd5);

    for (int i = 0; i < NV; i++) begin
      put(VEC[NV-1-i]);
      idle(1 + (i % 3), 18'sd30000);
    end
    idle(12, -18'sd7);

    for (int i = 0; i < 8; i++) put((i % 2) ? -18'sd65536 : 18'sd65535);
    idle(12, 18'sd0);

    put(18'sd500); put(18'sd600); put(18'sd700); put(18'sd800);
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    clear_model();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(vld == 1'b0 && dout == '0, "R1 after mid reset", dout, 0);
    idle(10, 18'sd9);
    put(18'sd1000); put(-18'sd2000);
    idle(12, 18'sd0);

    chk(rp == wp, "R3 all results seen", rp, wp);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule